// File: doc/BRIEF.md
# Randomised-Timing Cipher Operation Sequencer

This block sequences one block-cipher operation around a fixed-latency engine. A single-cycle write strobe asks for an operation. If the block is idle it accepts the request and latches the key length, the direction (encrypt or decrypt) and the timing-randomisation enable. When randomisation is on, the block waits a pseudo-random number of cycles (0 to 15) before it launches the engine. After the engine reports completion it waits a second, separately drawn number of cycles (0 to 15) before it signals the end of the operation. Shifting both edges of the engine's activity this way makes power traces harder to align for side-channel analysis.

While an operation is in flight, a busy output is held high so that the owner of the shared key/data memory can keep other agents away from it. Completion is reported by a sticky done flag, which software can poll, and by an interrupt line gated with an enable. A request that arrives while the block is busy is dropped and raises a sticky error flag. The cipher datapath is not part of this block. It is represented by a cycle-count stub whose latency depends on the key length, and its active window is visible on an output.

Top module: `aes_jitter_seq`

## Requirements
- R1: After reset `busy`, `doneFlag`, `errFlag`, `irq`, `engRun` and `engDecrypt` are all 0.
- R2: A request (`startWr` high at a rising edge while `busy` is 0) is accepted at that edge. From the next cycle `busy` is 1, and `doneFlag` and `errFlag` are 0. The block latches `keySize`, `decrypt` and `jitterEn` at that edge, and later changes to these inputs have no effect on the operation in flight.
- R3: The random source is a 16-bit shift register loaded with 16'hACE1 at reset. It shifts left by one bit at every clock edge out of reset, and the new bit 0 is bit15 XOR bit13 XOR bit12 XOR bit10. The pre-delay P is its bits [3:0] at the accept edge. The post-delay Q is its bits [7:4] at the edge where the engine finishes. Both delays are 0 when the latched `jitterEn` is 0.
- R4: The engine latency L depends on the latched key length: `keySize` 0 gives 55 cycles (128-bit key), 1 gives 70 (192-bit), and 2 or 3 give 75 (256-bit). With the accept edge at E, `engRun` is 1 from edge E+P+1 up to edge E+P+L-1.
- R5: With randomisation off, `busy` is high for exactly L cycles, and `doneFlag` rises at edge E+L.
- R6: With randomisation on, `doneFlag` rises at edge E+P+L+Q, so `busy` stays high for between L and L+30 cycles.
- R7: A request while `busy` is 1 is ignored: the timing and direction of the running operation are unchanged. It sets `errFlag` at that edge, and the flag holds until the next accepted request.
- R8: `busy` falls at the same edge at which `doneFlag` rises. `doneFlag` then holds until the next accepted request.
- R9: `irq` is 1 exactly when `doneFlag` and `irqEn` are both 1. `irqEn` acts at once and is not latched.
- R10: `engDecrypt` takes the latched direction at the edge where the engine launches and holds it until the next launch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startWr | input | 1 | Operation request strobe (control write) |
| jitterEn | input | 1 | Enable random pre/post delays |
| keySize | input | 2 | Key length code: 0=128, 1=192, 2/3=256 |
| decrypt | input | 1 | 1 = decrypt, 0 = encrypt |
| irqEn | input | 1 | Interrupt enable |
| busy | output | 1 | Operation in flight; shared memory is owned |
| doneFlag | output | 1 | Sticky completion status |
| errFlag | output | 1 | Sticky request-while-busy error |
| irq | output | 1 | Completion interrupt |
| engRun | output | 1 | Engine stub active window |
| engDecrypt | output | 1 | Direction applied to the engine |

## Verification
The interesting coincidence is a new request arriving at the same edge at which the post-delay expires. At that edge the block is still busy, so the request must be rejected with the error flag set, while `doneFlag` rises and `busy` falls. The bench provokes this by using its own model's predicted finishing edge to place the strobe exactly there. It then checks that `doneFlag` and `errFlag` are both set and `busy` is clear, and that no new operation starts. A per-cycle behavioural model, which keeps its own copy of the random register taken from R3, is compared with every output on every cycle. This pins the exact pre- and post-delay edges under randomised timing.

// File: rtl/aes_jit_pkg.sv
package aes_jit_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PRE  = 2'd1,
    ST_RUN  = 2'd2,
    ST_POST = 2'd3
  } seqState_e;

  // strobes from control to the engine stub
  typedef struct packed {
    logic       launch;
    logic [1:0] keySel;
    logic       decrypt;
  } engStrobe_t;
endpackage

// File: rtl/aes_jit_datapath.sv
module aes_jit_datapath
  import aes_jit_pkg::*;
#(
  parameter int LFSR_W = 16,
  parameter logic [LFSR_W-1:0] SEED = 16'hACE1,
  parameter logic [LFSR_W-1:0] TAPS = 16'hB400,
  parameter int NIB_W = 4,
  parameter int LAT128 = 55,
  parameter int LAT192 = 70,
  parameter int LAT256 = 75
) (
  input  logic             clk,
  input  logic             rstN,
  input  engStrobe_t       strb,
  output logic [NIB_W-1:0] rndPre,
  output logic [NIB_W-1:0] rndPost,
  output logic             engDone,
  output logic             engRun,
  output logic             engDecrypt
);
  localparam int CW = $clog2(LAT256 + 1);
  // the two control handoff cycles are absorbed in the stub count
  localparam int TRIM = 3;

  logic [LFSR_W-1:0] lfsr;
  logic              fb;
  logic [CW-1:0]     engCnt;
  logic [CW-1:0]     loadVal;

  assign fb = ^(lfsr & TAPS);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lfsr <= SEED;
    else       lfsr <= {lfsr[LFSR_W-2:0], fb};
  end

  assign rndPre  = lfsr[NIB_W-1:0];
  assign rndPost = lfsr[2*NIB_W-1:NIB_W];

  always_comb begin
    unique case (strb.keySel)
      2'd0:    loadVal = CW'(LAT128 - TRIM);
      2'd1:    loadVal = CW'(LAT192 - TRIM);
      default: loadVal = CW'(LAT256 - TRIM);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      engRun     <= 1'b0;
      engCnt     <= '0;
      engDecrypt <= 1'b0;
    end else if (strb.launch) begin
      engRun     <= 1'b1;
      engCnt     <= loadVal;
      engDecrypt <= strb.decrypt;
    end else if (engRun) begin
      if (engCnt == '0) engRun <= 1'b0;
      else              engCnt <= engCnt - 1'b1;
    end
  end

  assign engDone = engRun && (engCnt == '0);
endmodule

// File: rtl/aes_jit_ctrl.sv
module aes_jit_ctrl
  import aes_jit_pkg::*;
#(
  parameter int NIB_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startWr,
  input  logic             jitterEn,
  input  logic [1:0]       keySize,
  input  logic             decrypt,
  input  logic [NIB_W-1:0] rndPre,
  input  logic [NIB_W-1:0] rndPost,
  input  logic             engDone,
  output engStrobe_t       strb,
  output logic             busy,
  output logic             doneFlag,
  output logic             errFlag
);
  seqState_e        state;
  logic [NIB_W-1:0] cnt;
  logic [1:0]       keyQ;
  logic             decQ;
  logic             jitQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      keyQ     <= 2'd0;
      decQ     <= 1'b0;
      jitQ     <= 1'b0;
      doneFlag <= 1'b0;
      errFlag  <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (startWr) begin
          state    <= ST_PRE;
          cnt      <= jitterEn ? rndPre : '0;
          keyQ     <= keySize;
          decQ     <= decrypt;
          jitQ     <= jitterEn;
          doneFlag <= 1'b0;
          errFlag  <= 1'b0;
        end
        ST_PRE: begin
          if (cnt == '0) state <= ST_RUN;
          else           cnt   <= cnt - 1'b1;
        end
        ST_RUN: if (engDone) begin
          state <= ST_POST;
          cnt   <= jitQ ? rndPost : '0;
        end
        ST_POST: begin
          if (cnt == '0) begin
            state    <= ST_IDLE;
            doneFlag <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
      if (startWr && state != ST_IDLE) errFlag <= 1'b1;
    end
  end

  assign strb.launch  = (state == ST_PRE) && (cnt == '0);
  assign strb.keySel  = keyQ;
  assign strb.decrypt = decQ;
  assign busy         = (state != ST_IDLE);
endmodule

// File: rtl/aes_jitter_seq.sv
module aes_jitter_seq
  import aes_jit_pkg::*;
#(
  parameter int LFSR_W = 16,
  parameter logic [LFSR_W-1:0] SEED = 16'hACE1,
  parameter logic [LFSR_W-1:0] TAPS = 16'hB400,
  parameter int NIB_W = 4,
  parameter int LAT128 = 55,
  parameter int LAT192 = 70,
  parameter int LAT256 = 75
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startWr,
  input  logic       jitterEn,
  input  logic [1:0] keySize,
  input  logic       decrypt,
  input  logic       irqEn,
  output logic       busy,
  output logic       doneFlag,
  output logic       errFlag,
  output logic       irq,
  output logic       engRun,
  output logic       engDecrypt
);
  engStrobe_t       strb;
  logic [NIB_W-1:0] rndPre;
  logic [NIB_W-1:0] rndPost;
  logic             engDone;

  aes_jit_ctrl #(.NIB_W(NIB_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .startWr(startWr), .jitterEn(jitterEn),
    .keySize(keySize), .decrypt(decrypt), .rndPre(rndPre), .rndPost(rndPost),
    .engDone(engDone), .strb(strb), .busy(busy), .doneFlag(doneFlag),
    .errFlag(errFlag)
  );

  aes_jit_datapath #(
    .LFSR_W(LFSR_W), .SEED(SEED), .TAPS(TAPS), .NIB_W(NIB_W),
    .LAT128(LAT128), .LAT192(LAT192), .LAT256(LAT256)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .rndPre(rndPre), .rndPost(rndPost),
    .engDone(engDone), .engRun(engRun), .engDecrypt(engDecrypt)
  );

  assign irq = doneFlag & irqEn;
endmodule

// File: rtl/aes_jitter_seq_chk.sv
module aes_jitter_seq_chk (
  input logic clk,
  input logic rstN,
  input logic startWr,
  input logic irqEn,
  input logic busy,
  input logic doneFlag,
  input logic errFlag,
  input logic irq,
  input logic engRun,
  input logic engDecrypt
);
  AST_BUSY_START_ERR: assert property (@(posedge clk) disable iff (!rstN)
    (busy && startWr) |=> errFlag); // R7
  AST_BUSY_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(startWr)); // R2
  AST_ACCEPT_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (!doneFlag && !errFlag)); // R2
  AST_ENG_IN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    engRun |-> busy); // R4
  AST_DONE_WITH_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneFlag) |-> $fell(busy)); // R8
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (doneFlag && !startWr) |=> doneFlag); // R8
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (doneFlag && irqEn)); // R9
  AST_DIR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (engRun && $past(engRun)) |-> $stable(engDecrypt)); // R10
endmodule

bind aes_jitter_seq aes_jitter_seq_chk u_chk (
  .clk(clk), .rstN(rstN), .startWr(startWr), .irqEn(irqEn), .busy(busy),
  .doneFlag(doneFlag), .errFlag(errFlag), .irq(irq), .engRun(engRun),
  .engDecrypt(engDecrypt)
);

// File: tb/aes_jitter_seq_tb.sv
module aes_jitter_seq_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startWr = 1'b0;
  logic jitterEn = 1'b0;
  logic [1:0] keySize = 2'd0;
  logic decrypt = 1'b0;
  logic irqEn = 1'b0;
  logic busy, doneFlag, errFlag, irq, engRun, engDecrypt;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  aes_jitter_seq u_dut (
    .clk(clk), .rstN(rstN), .startWr(startWr), .jitterEn(jitterEn),
    .keySize(keySize), .decrypt(decrypt), .irqEn(irqEn), .busy(busy),
    .doneFlag(doneFlag), .errFlag(errFlag), .irq(irq), .engRun(engRun),
    .engDecrypt(engDecrypt)
  );

  always #10 clk = ~clk;

  // ---------------- behavioural reference model ----------------
  int mK;
  logic [15:0] mLfsr;
  bit mBusy, mDone, mErr, mRun, mDec, pendDec, pendJit;
  int engS, engE, doneE;

  function automatic int latOf(input logic [1:0] k);
    if (k == 2'd0) return 55;
    if (k == 2'd1) return 70;
    return 75;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mK = 0; mLfsr = 16'hACE1;
      mBusy = 0; mDone = 0; mErr = 0; mRun = 0; mDec = 0;
      pendDec = 0; pendJit = 0;
      engS = 1 << 30; engE = 1 << 30; doneE = 1 << 30;
    end else begin
      if (mBusy) begin
        if (mK == engS) begin mRun = 1; mDec = pendDec; end
        if (mK == engE) begin
          mRun = 0;
          doneE = mK + (pendJit ? int'(mLfsr[7:4]) : 0) + 1;
        end
        if (mK == doneE) begin mBusy = 0; mDone = 1; end
        if (startWr) mErr = 1;
      end else if (startWr) begin
        int p;
        p = jitterEn ? int'(mLfsr[3:0]) : 0;
        engS = mK + p + 1;
        engE = mK + p + latOf(keySize) - 1;
        doneE = 1 << 30;
        mBusy = 1; mDone = 0; mErr = 0;
        pendDec = decrypt; pendJit = jitterEn;
      end
      mLfsr = {mLfsr[14:0], mLfsr[15] ^ mLfsr[13] ^ mLfsr[12] ^ mLfsr[10]};
      mK++;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      total++;
      if (busy !== mBusy) begin bad++; $display("FAIL R6 busy act=%0b exp=%0b k=%0d", busy, mBusy, mK); end
      if (doneFlag !== mDone) begin bad++; $display("FAIL R8 doneFlag act=%0b exp=%0b k=%0d", doneFlag, mDone, mK); end
      if (errFlag !== mErr) begin bad++; $display("FAIL R7 errFlag act=%0b exp=%0b k=%0d", errFlag, mErr, mK); end
      if (engRun !== mRun) begin bad++; $display("FAIL R4 engRun act=%0b exp=%0b k=%0d", engRun, mRun, mK); end
      if (engDecrypt !== mDec) begin bad++; $display("FAIL R10 engDecrypt act=%0b exp=%0b k=%0d", engDecrypt, mDec, mK); end
      if (irq !== (mDone && irqEn)) begin bad++; $display("FAIL R9 irq act=%0b exp=%0b k=%0d", irq, mDone && irqEn, mK); end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      bad++; total++;
      $display("FAIL watchdog act=%0d exp<=150000 cycles", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic pulseStart();
    @(posedge clk); #2 startWr = 1'b1;
    @(posedge clk); #2 startWr = 1'b0;
  endtask

  // run one operation and return the number of cycles busy was observed high
  task automatic runOp(input logic [1:0] k, input logic jit, input logic dir,
                       output int n);
    @(posedge clk); #2 keySize = k; jitterEn = jit; decrypt = dir;
    pulseStart();
    n = 0;
    forever begin
      @(negedge clk);
      if (busy) n++;
      else break;
    end
  endtask

  initial begin
    int n;
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1 outputs after reset", {busy, doneFlag, errFlag, irq, engRun, engDecrypt}, 0);

    // R4/R5: fixed latency with randomisation off, every key code
    irqEn = 1'b1;
    for (int k = 0; k < 4; k++) begin
      runOp(2'(k), 1'b0, k[0], n);
      check("R5 busy cycles jitter off", n, latOf(2'(k)));
      check("R8 done after op", int'(doneFlag), 1);
    end

    // R6/R3: randomised timing, bounds plus per-cycle model
    for (int i = 0; i < 6; i++) begin
      runOp(2'(i % 3), 1'b1, i[0], n);
      total++;
      if (n < latOf(2'(i % 3)) || n > latOf(2'(i % 3)) + 30) begin
        bad++;
        $display("FAIL R6 busy cycles act=%0d exp=%0d..%0d", n, latOf(2'(i % 3)), latOf(2'(i % 3)) + 30);
      end
    end

    // R7/R2/R10: request while busy, input changes mid-operation
    @(posedge clk); #2 keySize = 2'd0; jitterEn = 1'b1; decrypt = 1'b1;
    pulseStart();
    repeat (5) @(posedge clk);
    #2 keySize = 2'd2; decrypt = 1'b0; jitterEn = 1'b0;
    pulseStart();
    @(negedge clk);
    check("R7 err set by busy request", int'(errFlag), 1);
    while (busy) @(negedge clk);
    check("R7 err held to end", int'(errFlag), 1);
    check("R2 done after ignored request", int'(doneFlag), 1);
    check("R10 direction kept", int'(engDecrypt), 1);

    // R2: accepted request clears done and error
    pulseStart();
    @(negedge clk);
    check("R2 done cleared on accept", int'(doneFlag), 0);
    check("R2 err cleared on accept", int'(errFlag), 0);
    while (busy) @(negedge clk);

    // R9: interrupt gating
    @(posedge clk); #2 irqEn = 1'b0;
    @(negedge clk);
    check("R9 irq masked", int'(irq), 0);
    @(posedge clk); #2 irqEn = 1'b1;
    @(negedge clk);
    check("R9 irq unmasked", int'(irq), 1);

    // collision: request at the very edge the post-delay expires
    @(posedge clk); #2 keySize = 2'd1; jitterEn = 1'b1; decrypt = 1'b0;
    pulseStart();
    forever begin
      @(posedge clk); #2;
      if (mK == doneE) break;
    end
    startWr = 1'b1;
    @(posedge clk); #2 startWr = 1'b0;
    @(negedge clk);
    check("R8 done at collision edge", int'(doneFlag), 1);
    check("R7 err at collision edge", int'(errFlag), 1);
    check("R7 no new operation after collision", int'(busy), 0);
    repeat (4) @(negedge clk);
    check("R7 still idle", int'(busy), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule